// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits on the device side of a flash emulator. It watches the bus write cycles a host issues, each one an address, a data word and a write strobe. It checks them against the handshake that guards every write-class operation. Each operation starts with a fixed two-write unlock prefix, followed by a command byte. A program then takes one further write that carries the target address and data. An erase repeats the prefix once more and ends with a sixth write that chooses the erase scope. When a sequence completes, the block emits a single-cycle request to the program/erase engine or to the mode logic.

The block also holds the current read mode: normal array data, identification codes or query table. It drives the identification word for the read path while the identification mode is active. Any write that breaks a sequence drops the machine back to its start and returns the mode to normal reads. While the engine reports that it is busy, completed writes have no effect at all.

The strobe is sampled on the clock. The write address is taken when the strobe is first seen high, and the write data when it is first seen low again. The decision on that write is made one clock later.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `req_valid` is 0, `mode` is 0 (normal reads) and `id_word` is 0.
- R2: An unlock prefix is low byte AAh at an address whose low 15 bits are 5555h, then low byte 55h at low bits 2AAAh. Address bits above bit 14 and data bits 15..8 do not affect matching.
- R3: After the prefix, A0h at 5555h arms a program. The next write issues `req_kind` 1 with `req_addr`/`req_data` equal to that write's address and data, and sets `mode` to 0.
- R4: Prefix, 80h at 5555h, a second prefix, then 10h at 5555h issues `req_kind` 4 (whole-array erase) with `req_addr` 0.
- R5: The same six-write form ending in 30h at any address issues `req_kind` 2 (sector erase). `req_addr` is that address with bits 10..0 cleared, giving 2K-word sectors.
- R6: The six-write form ending in 50h issues `req_kind` 3 (block erase). `req_addr` is that address with bits 14..0 cleared, giving 32K-word blocks.
- R7: Prefix then 90h at 5555h issues `req_kind` 5 and sets `mode` 1 (identification). Prefix then 98h at 5555h issues `req_kind` 6 and sets `mode` 2 (query).
- R8: F0h in the first write of a sequence (any address), or F0h at 5555h after a prefix, issues `req_kind` 7 with `req_addr` equal to that write's address, and sets `mode` 0.
- R9: A write that does not match the expected step issues no request, sets `mode` to 0 and returns the machine to the start. The write is not reinterpreted as a new start.
- R10: A write whose decision cycle sees `busy` high is ignored: no request, and both the sequence position and `mode` stay unchanged. `busy` while the strobe is high does not matter.
- R11: In mode 1, `id_word` one cycle after `rd_addr` is 007Fh for 0000h, 0020h for 0001h, 007Fh for 0003h and 001Fh for 0040h. It is 0 for any other address and in any other mode.
- R12: A request is a one-cycle `req_valid` pulse. It appears in the second clock after the strobe is sampled low. The address is captured at the strobe's rising sample and the data at its falling sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_strobe | input | 1 | Bus write strobe, active high |
| wr_addr | input | AW (19) | Bus write address |
| wr_data | input | DW (16) | Bus write data |
| busy | input | 1 | Program/erase engine running |
| rd_addr | input | MATCH_W (15) | Low read address bits for the identification lookup |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 3 | Request type: 1 program, 2 sector erase, 3 block erase, 4 array erase, 5 ident entry, 6 query entry, 7 exit |
| req_addr | output | AW (19) | Request address |
| req_data | output | DW (16) | Request data (program word) |
| mode | output | 2 | Read mode: 0 normal, 1 identification, 2 query |
| id_word | output | DW (16) | Identification word for the read path |

## Verification
The two events that can fall on the same clock are the decision on a completed write and a change of the engine's `busy` flag. The bench moves `busy` so that it is high only on the decision cycle in some writes. In others it is high only while the strobe is asserted. A write seen as busy must leave no request and no change of mode or sequence position. The later, idle-decided write must then complete the sequence as if the ignored one had never happened. A write that was busy only during its strobe must be accepted normally.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    REQ_NONE  = 3'd0,
    REQ_PROG  = 3'd1,
    REQ_SECT  = 3'd2,
    REQ_BLK   = 3'd3,
    REQ_CHIP  = 3'd4,
    REQ_IDENT = 3'd5,
    REQ_QUERY = 3'd6,
    REQ_EXIT  = 3'd7
  } req_kind_e;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_IDENT = 2'd1,
    MODE_QUERY = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_KEY1   = 3'd1,
    ST_CMD    = 3'd2,
    ST_PROG   = 3'd3,
    ST_EKEY0  = 3'd4,
    ST_EKEY1  = 3'd5,
    ST_ECMD   = 3'd6
  } seq_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_EXIT    = 8'hF0;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECT    = 8'h30;
  localparam logic [7:0] OP_BLK     = 8'h50;

endpackage

// File: rtl/bus_write_capture.sv
module bus_write_capture #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          cyc_valid,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);

  logic          strobe_q;
  logic [AW-1:0] addr_hold;
  logic          strobe_rise;
  logic          strobe_fall;

  assign strobe_rise = strobe & ~strobe_q;
  assign strobe_fall = ~strobe & strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      addr_hold <= '0;
      cyc_valid <= 1'b0;
      cyc_addr  <= '0;
      cyc_data  <= '0;
    end else begin
      strobe_q  <= strobe;
      cyc_valid <= strobe_fall;
      if (strobe_rise) addr_hold <= addr;
      if (strobe_fall) begin
        cyc_addr <= addr_hold;
        cyc_data <= data;
      end
    end
  end

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int MATCH_W  = 15,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15,
  parameter int KEY_ADDR_A = 'h5555,
  parameter int KEY_ADDR_B = 'h2AAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  input  logic          busy,
  output logic          req_valid,
  output logic [2:0]    req_kind,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic [1:0]    mode
);

  localparam logic [AW-1:0]      SECT_MASK = {AW{1'b1}} << SECT_LSB;
  localparam logic [AW-1:0]      BLK_MASK  = {AW{1'b1}} << BLK_LSB;
  localparam logic [MATCH_W-1:0] MATCH_A   = MATCH_W'(KEY_ADDR_A);
  localparam logic [MATCH_W-1:0] MATCH_B   = MATCH_W'(KEY_ADDR_B);

  seq_state_e    state, state_n;
  logic [1:0]    mode_n;
  logic          rv_n;
  req_kind_e     rk_n;
  logic [AW-1:0] ra_n;
  logic [DW-1:0] rd_n;
  logic          mismatch;
  logic          at_a, at_b;
  logic [7:0]    op;

  assign at_a = (cyc_addr[MATCH_W-1:0] == MATCH_A);
  assign at_b = (cyc_addr[MATCH_W-1:0] == MATCH_B);
  assign op   = cyc_data[7:0];

  always_comb begin
    state_n  = state;
    mode_n   = mode;
    rv_n     = 1'b0;
    rk_n     = REQ_NONE;
    ra_n     = req_addr;
    rd_n     = req_data;
    mismatch = 1'b0;
    if (cyc_valid && !busy) begin
      state_n = ST_IDLE;
      unique case (state)
        ST_IDLE: begin
          if (at_a && op == KEY_FIRST) begin
            state_n = ST_KEY1;
          end else if (op == OP_EXIT) begin
            rv_n = 1'b1; rk_n = REQ_EXIT; ra_n = cyc_addr; rd_n = cyc_data;
            mode_n = MODE_READ;
          end else begin
            mismatch = 1'b1;
          end
        end
        ST_KEY1: begin
          if (at_b && op == KEY_SECOND) state_n = ST_CMD;
          else mismatch = 1'b1;
        end
        ST_CMD: begin
          if (!at_a) begin
            mismatch = 1'b1;
          end else begin
            unique case (op)
              OP_PROG:  state_n = ST_PROG;
              OP_ERASE: state_n = ST_EKEY0;
              OP_IDENT: begin
                rv_n = 1'b1; rk_n = REQ_IDENT; ra_n = cyc_addr; rd_n = cyc_data;
                mode_n = MODE_IDENT;
              end
              OP_QUERY: begin
                rv_n = 1'b1; rk_n = REQ_QUERY; ra_n = cyc_addr; rd_n = cyc_data;
                mode_n = MODE_QUERY;
              end
              OP_EXIT: begin
                rv_n = 1'b1; rk_n = REQ_EXIT; ra_n = cyc_addr; rd_n = cyc_data;
                mode_n = MODE_READ;
              end
              default: mismatch = 1'b1;
            endcase
          end
        end
        ST_PROG: begin
          rv_n = 1'b1; rk_n = REQ_PROG; ra_n = cyc_addr; rd_n = cyc_data;
          mode_n = MODE_READ;
        end
        ST_EKEY0: begin
          if (at_a && op == KEY_FIRST) state_n = ST_EKEY1;
          else mismatch = 1'b1;
        end
        ST_EKEY1: begin
          if (at_b && op == KEY_SECOND) state_n = ST_ECMD;
          else mismatch = 1'b1;
        end
        ST_ECMD: begin
          if (op == OP_CHIP && at_a) begin
            rv_n = 1'b1; rk_n = REQ_CHIP; ra_n = '0; rd_n = cyc_data;
            mode_n = MODE_READ;
          end else if (op == OP_SECT) begin
            rv_n = 1'b1; rk_n = REQ_SECT; ra_n = cyc_addr & SECT_MASK; rd_n = cyc_data;
            mode_n = MODE_READ;
          end else if (op == OP_BLK) begin
            rv_n = 1'b1; rk_n = REQ_BLK; ra_n = cyc_addr & BLK_MASK; rd_n = cyc_data;
            mode_n = MODE_READ;
          end else begin
            mismatch = 1'b1;
          end
        end
        default: mismatch = 1'b1;
      endcase
      if (mismatch) mode_n = MODE_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode      <= MODE_READ;
      req_valid <= 1'b0;
      req_kind  <= REQ_NONE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      state     <= state_n;
      mode      <= mode_n;
      req_valid <= rv_n;
      req_kind  <= rk_n;
      req_addr  <= ra_n;
      req_data  <= rd_n;
    end
  end

endmodule

// File: rtl/id_lookup.sv
module id_lookup #(
  parameter int MATCH_W = 15,
  parameter int DW      = 16,
  parameter int N_ID    = 4,
  parameter logic [N_ID*16-1:0] ID_ADDRS = {16'h0040, 16'h0003, 16'h0001, 16'h0000},
  parameter logic [N_ID*DW-1:0] ID_WORDS = {16'h001F, 16'h007F, 16'h0020, 16'h007F}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MATCH_W-1:0] rd_addr,
  input  logic               id_active,
  output logic [DW-1:0]      id_word
);

  logic [N_ID-1:0] hit;
  logic [DW-1:0]   word_n;

  for (genvar g = 0; g < N_ID; g++) begin : g_entry
    assign hit[g] = (rd_addr == MATCH_W'(ID_ADDRS[g*16 +: 16]));
  end

  always_comb begin
    word_n = '0;
    for (int i = 0; i < N_ID; i++) begin
      if (hit[i]) word_n = ID_WORDS[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) id_word <= '0;
    else     id_word <= id_active ? word_n : '0;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int MATCH_W  = 15,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_strobe,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               busy,
  input  logic [MATCH_W-1:0] rd_addr,
  output logic               req_valid,
  output logic [2:0]         req_kind,
  output logic [AW-1:0]      req_addr,
  output logic [DW-1:0]      req_data,
  output logic [1:0]         mode,
  output logic [DW-1:0]      id_word
);

  logic          cyc_valid;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  logic          id_active;

  bus_write_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .strobe    (wr_strobe),
    .addr      (wr_addr),
    .data      (wr_data),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .cyc_data  (cyc_data)
  );

  cmd_sequencer #(
    .AW(AW), .DW(DW), .MATCH_W(MATCH_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .cyc_data  (cyc_data),
    .busy      (busy),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .mode      (mode)
  );

  assign id_active = (mode == MODE_IDENT);

  id_lookup #(.MATCH_W(MATCH_W), .DW(DW)) u_ident (
    .clk       (clk),
    .rst       (rst),
    .rd_addr   (rd_addr),
    .id_active (id_active),
    .id_word   (id_word)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW       = 19,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_strobe,
  input logic          busy,
  input logic          req_valid,
  input logic [2:0]    req_kind,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    mode
);

  localparam logic [AW-1:0] SECT_LOW = ~({AW{1'b1}} << SECT_LSB);
  localparam logic [AW-1:0] BLK_LOW  = ~({AW{1'b1}} << BLK_LSB);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) req_valid |=> !req_valid); // R12
  AST_PULSE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) req_valid |-> (!$past(wr_strobe, 2) && $past(wr_strobe, 3))); // R12
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst) req_valid |-> !$past(busy)); // R10
  AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (rst) (req_valid && req_kind == 3'd2) |-> ((req_addr & SECT_LOW) == '0)); // R5
  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (rst) (req_valid && req_kind == 3'd3) |-> ((req_addr & BLK_LOW) == '0)); // R6
  AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (rst) (req_valid && req_kind == 3'd4) |-> (req_addr == '0)); // R4
  AST_IDENT_MODE: assert property (@(posedge clk) disable iff (rst) (req_valid && req_kind == 3'd5) |-> (mode == 2'd1)); // R7
  AST_EXIT_MODE: assert property (@(posedge clk) disable iff (rst) (req_valid && req_kind == 3'd7) |-> (mode == 2'd0)); // R8
  AST_MODE_CODE: assert property (@(posedge clk) disable iff (rst) mode != 2'd3); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst) $past(busy) && !$past(rst) |-> $stable(mode)); // R10

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .AW(AW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_strobe (wr_strobe),
  .busy      (busy),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_addr  (req_addr),
  .mode      (mode)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_strobe = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [14:0] rd_addr = '0;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [18:0] req_addr;
  logic [15:0] req_data;
  logic [1:0]  mode;
  logic [15:0] id_word;

  always #2 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .mode(mode), .id_word(id_word)
  );

  typedef struct packed {
    logic [18:0] a;
    logic [15:0] d;
    logic        be;
    logic [2:0]  k;
    logic [18:0] ea;
    logic [15:0] ed;
    logic [1:0]  m;
  } vec_t;

  function automatic vec_t mk(input logic [18:0] a, input logic [15:0] d, input logic be,
                              input logic [2:0] k, input logic [18:0] ea, input logic [15:0] ed,
                              input logic [1:0] m);
    return '{a, d, be, k, ea, ed, m};
  endfunction

  function automatic vec_t st(input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
    return '{a, d, 1'b0, 3'd0, 19'h0, 16'h0, m};
  endfunction

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    // R3 program
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0), st(19'h05555, 16'h00A0, 0),
    mk(19'h12345, 16'hBEEF, 0, 1, 19'h12345, 16'hBEEF, 0),
    // R2 upper address bits and high data byte ignored
    st(19'h7D555, 16'h12AA, 0), st(19'h4AAAA, 16'hFF55, 0), st(19'h0D555, 16'h33A0, 0),
    mk(19'h00010, 16'h0001, 0, 1, 19'h00010, 16'h0001, 0),
    // R4 whole-array erase
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0), st(19'h05555, 16'h0080, 0),
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h05555, 16'h0010, 0, 4, 19'h00000, 16'h0, 0),
    // R5 sector erase
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0), st(19'h05555, 16'h0080, 0),
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h5ABCD, 16'h0030, 0, 2, 19'h5A800, 16'h0, 0),
    // R6 block erase
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0), st(19'h05555, 16'h0080, 0),
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h3F123, 16'h0050, 0, 3, 19'h38000, 16'h0, 0),
    // R7 ident entry
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h05555, 16'h0090, 0, 5, 19'h05555, 16'h0, 1),
    // R8 single-write exit
    mk(19'h01234, 16'h00F0, 0, 7, 19'h01234, 16'h0, 0),
    // R7 query entry
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h05555, 16'h0098, 0, 6, 19'h05555, 16'h0, 2),
    // R8 exit after prefix
    st(19'h05555, 16'h00AA, 2), st(19'h02AAA, 16'h0055, 2),
    mk(19'h05555, 16'h00F0, 0, 7, 19'h05555, 16'h0, 0),
    // R9 bad second key, then a clean program
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0044, 0),
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0), st(19'h05555, 16'h00A0, 0),
    mk(19'h00020, 16'h0001, 0, 1, 19'h00020, 16'h0001, 0),
    // R9 abort inside erase prefix drops ident mode
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h05555, 16'h0090, 0, 5, 19'h05555, 16'h0, 1),
    st(19'h05555, 16'h00AA, 1), st(19'h02AAA, 16'h0055, 1), st(19'h05555, 16'h0080, 1),
    st(19'h02AAA, 16'h0056, 0),
    // R9 wrong key address; following writes are not a sequence
    st(19'h05554, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0), st(19'h05555, 16'h00A0, 0),
    st(19'h00030, 16'h0001, 0),
    // R10 busy at decision keeps ident mode
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h05555, 16'h0090, 0, 5, 19'h05555, 16'h0, 1),
    mk(19'h00000, 16'h00F0, 1, 0, 19'h0, 16'h0, 1),
    mk(19'h00000, 16'h00F0, 0, 7, 19'h00000, 16'h0, 0),
    // R10 busy at decision keeps sequence position
    st(19'h05555, 16'h00AA, 0), st(19'h02AAA, 16'h0055, 0),
    mk(19'h05555, 16'h00A0, 1, 0, 19'h0, 16'h0, 0),
    st(19'h05555, 16'h00A0, 0),
    mk(19'h00100, 16'h5A5A, 0, 1, 19'h00100, 16'h5A5A, 0)
  };

  int n_chk = 0;
  int n_fail = 0;
  logic        g_v;
  logic [2:0]  g_k;
  logic [18:0] g_a;
  logic [15:0] g_d;
  logic [1:0]  g_m;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd1: return "R3 program";
      3'd2: return "R5 sector";
      3'd3: return "R6 block";
      3'd4: return "R4 array";
      3'd5: return "R7 ident";
      3'd6: return "R7 query";
      3'd7: return "R8 exit";
      default: return "R9/R10 no request";
    endcase
  endfunction

  task automatic wr(input logic [18:0] a, input logic [15:0] d, input logic bs, input logic be);
    @(negedge clk);
    wr_addr = a; wr_data = ~d; wr_strobe = 1'b1; busy = bs;
    @(negedge clk);
    wr_addr = ~a; wr_data = d;
    @(negedge clk);
    wr_strobe = 1'b0;
    @(negedge clk);
    busy = be; wr_data = ~d;
    @(negedge clk);
    g_v = req_valid; g_k = req_kind; g_a = req_addr; g_d = req_data; g_m = mode;
    busy = 1'b0;
    if (g_v) begin
      @(negedge clk);
      chk(req_valid == 1'b0, "R12 single-cycle pulse", {31'd0, req_valid}, 32'd0);
    end
  endtask

  task automatic rd(input logic [14:0] a, input logic [15:0] exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(id_word == exp, "R11 ident read", {16'd0, id_word}, {16'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req_valid == 1'b0, "R1 req_valid", {31'd0, req_valid}, 32'd0);
    chk(mode == 2'd0, "R1 mode", {30'd0, mode}, 32'd0);
    chk(id_word == 16'd0, "R1 id_word", {16'd0, id_word}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d, 1'b0, VEC[i].be);
      chk(g_v == (VEC[i].k != 3'd0), kind_tag(VEC[i].k), {31'd0, g_v}, i);
      if (VEC[i].k != 3'd0) begin
        chk(g_k == VEC[i].k, kind_tag(VEC[i].k), {29'd0, g_k}, {29'd0, VEC[i].k});
        chk(g_a == VEC[i].ea, kind_tag(VEC[i].k), {13'd0, g_a}, {13'd0, VEC[i].ea});
        if (VEC[i].k == 3'd1)
          chk(g_d == VEC[i].ed, "R12 data captured at fall", {16'd0, g_d}, {16'd0, VEC[i].ed});
      end
      chk(g_m == VEC[i].m, "R9 mode after write", {30'd0, g_m}, {30'd0, VEC[i].m});
    end

    // R11 identification reads
    wr(19'h05555, 16'h00AA, 1'b0, 1'b0);
    wr(19'h02AAA, 16'h0055, 1'b0, 1'b0);
    wr(19'h05555, 16'h0090, 1'b0, 1'b0);
    rd(15'h0000, 16'h007F);
    rd(15'h0001, 16'h0020);
    rd(15'h0003, 16'h007F);
    rd(15'h0040, 16'h001F);
    rd(15'h0002, 16'h0000);
    wr(19'h00000, 16'h00F0, 1'b0, 1'b0);
    rd(15'h0000, 16'h0000);

    // R10 busy only while strobe high: accepted (R12 capture timing)
    wr(19'h05555, 16'h00AA, 1'b1, 1'b0);
    wr(19'h02AAA, 16'h0055, 1'b1, 1'b0);
    wr(19'h05555, 16'h00A0, 1'b1, 1'b0);
    wr(19'h00200, 16'h1111, 1'b1, 1'b0);
    chk(g_v && g_k == 3'd1, "R10 busy during strobe only", {28'd0, g_v, g_k}, 32'h9);
    chk(g_a == 19'h00200, "R12 address at rise", {13'd0, g_a}, 32'h200);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule